// File: doc/BRIEF.md
# Control Endpoint Zero Engine

This block is the device-side engine for control transfers on endpoint zero. It sits above a packet-level serial engine, which delivers decoded tokens, received data bytes and host handshakes. In return the block issues handshake responses and streams outgoing data bytes. The eight-byte setup packet is captured into its own small buffer. Data-stage bytes pass through one IN buffer and one OUT buffer. The block follows each transfer through its setup, data and status phases in hardware, and latches a separate interrupt request at the end of each phase.

A local CPU drives the transfer through a byte-wide register port. The CPU reads the setup bytes, fills and arms the IN buffer with a byte count, and reads and then releases the OUT buffer. It can also force a stall and acknowledge interrupts. The endpoint-valid register is fixed: both of its bits always read as one. The data-stage direction comes from bit 7 of the first setup byte. The status stage runs in the opposite direction, or as IN when the setup's length field is zero.

Top module: `ep0_engine`

## Requirements
- R1: After reset the phase output is 0 (idle), all three interrupt outputs are low, resp_valid is low, and the interrupt register (0x8B) reads 0.
- R2: A SETUP token (tok_pid 0) to endpoint 0 followed by exactly eight bytes and rx_end returns resp_code 0 (ACK) in the next cycle. It stores the bytes at 0x80-0x87, sets irq_setup, and moves the phase to 1 (data) when byte 6 or byte 7 is non-zero, otherwise to 2 (status).
- R3: Tokens addressed to any endpoint other than 0 get no response, and their bytes change neither the setup buffer, the interrupts nor the phase.
- R4: In the data phase of an IN transfer (setup byte 0 bit 7 set), IN tokens (tok_pid 2) are answered NAK (1) until the CPU writes a count to 0x88. After that they are answered DATA (3) with tx_len equal to the count clamped to the buffer size, and the buffer bytes stream on tx_data, one per cycle, with tx_last on the final byte.
- R5: ack_in after a data-stage IN packet sets irq_data and clears the armed flag (0x8A bit 1), so the buffer can be armed again.
- R6: In the data phase of an OUT transfer, an OUT token (tok_pid 1) with its bytes is ACKed. The bytes land at 0x40 onward, the count reads at 0x89, and irq_data is set. While that buffer is unreleased (0x8A bit 2), further OUT packets get NAK and leave it unchanged. A write to 0x89 releases it.
- R7: An IN status stage is answered DATA with tx_len 0, or NAK while the OUT buffer is unreleased; ack_in then sets irq_status and returns the phase to 0. An OUT status stage is ACKed, sets irq_status and returns the phase to 0.
- R8: While the stall bit (0x8A bit 0) is set and the phase is not idle, IN and OUT tokens are answered STALL (2).
- R9: A new SETUP aborts the transfer in progress: it clears the stall bit, the IN armed flag and the OUT busy flag, then restarts phase tracking.
- R10: Interrupt register 0x8B holds setup, data and status requests in bits 0, 1 and 2. Writing 1 to a bit clears it; writing 0 leaves it.
- R11: Register 0x8C (IN valid bit 0, OUT valid bit 1) always reads 0x03, whatever is written to it.
- R12: In the idle phase, IN and OUT tokens to endpoint 0 are answered NAK.
- R13: A SETUP whose packet does not hold exactly eight bytes gets no response, no irq_setup, and leaves the phase idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token strobe |
| tok_pid | input | 2 | Token kind: 0 SETUP, 1 OUT, 2 IN |
| tok_ep | input | 4 | Token endpoint number |
| rx_valid | input | 1 | Received data byte strobe |
| rx_data | input | 8 | Received data byte |
| rx_end | input | 1 | End of a good received data packet |
| ack_in | input | 1 | Host acknowledged the last IN data packet |
| resp_valid | output | 1 | Handshake response strobe |
| resp_code | output | 2 | 0 ACK, 1 NAK, 2 STALL, 3 DATA |
| tx_len | output | 7 | Byte count of the DATA response |
| tx_valid | output | 1 | Outgoing data byte valid |
| tx_data | output | 8 | Outgoing data byte |
| tx_last | output | 1 | Final outgoing byte |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 8 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| irq_setup | output | 1 | Setup-received request |
| irq_data | output | 1 | Data-packet-done request |
| irq_status | output | 1 | Status-done request |
| ctl_phase | output | 2 | 0 idle, 1 data, 2 status |

## Verification
A table of setup packets covers IN and OUT directions with zero and non-zero lengths, which separates the two direction bits and the two phase outcomes after setup. Full control-read and control-write sequences then show that data and status directions follow the setup. A refused OUT packet is shown to leave the buffer intact. An oversized arm count exposes the clamp at 64 bytes. Stall, abort by a new SETUP, foreign endpoints and a short setup packet each show a response that differs from the normal path.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
    typedef enum logic [1:0] {PID_SETUP = 2'd0, PID_OUT = 2'd1, PID_IN = 2'd2, PID_NONE = 2'd3} pid_e;
    typedef enum logic [1:0] {HS_ACK = 2'd0, HS_NAK = 2'd1, HS_STALL = 2'd2, HS_DATA = 2'd3} hs_e;
    typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_DATA = 2'd1, PH_STATUS = 2'd2} phase_e;
    typedef enum logic [1:0] {RX_NONE = 2'd0, RX_SETUP = 2'd1, RX_OUT = 2'd2} rxk_e;
    localparam int SETUP_LEN  = 8;
    localparam int IRQ_SETUP  = 0;
    localparam int IRQ_DATA   = 1;
    localparam int IRQ_STATUS = 2;
endpackage

// File: rtl/ep0_bytebuf.sv
module ep0_bytebuf #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ep0_ctl.sv
module ep0_ctl import ep0_pkg::*; #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_valid,
    input  logic [1:0]    tok_pid,
    input  logic [3:0]    tok_ep,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_end,
    input  logic          ack_in,
    input  logic          wr_stall,
    input  logic          wr_irq,
    input  logic          wr_in_cnt,
    input  logic          wr_out_rel,
    input  logic [7:0]    cpu_wdata,
    output logic          setup_we,
    output logic [2:0]    setup_waddr,
    output logic          out_we,
    output logic [AW-1:0] out_waddr,
    output logic [AW-1:0] tx_raddr,
    output logic          resp_valid,
    output logic [1:0]    resp_code,
    output logic [CW-1:0] tx_len,
    output logic          tx_valid,
    output logic          tx_last,
    output logic [1:0]    phase,
    output logic [2:0]    irq,
    output logic          stall,
    output logic          in_busy,
    output logic [CW-1:0] in_cnt,
    output logic          out_busy,
    output logic [CW-1:0] out_cnt
);
    typedef struct packed {
        phase_e        phase;
        rxk_e          rxk;
        logic          take;
        logic [CW-1:0] rx_cnt;
        logic          dir_in;
        logic          wl_nz;
        logic          stall;
        logic          in_busy;
        logic [CW-1:0] in_cnt;
        logic          out_busy;
        logic [CW-1:0] out_cnt;
        logic          in_sent;
        logic          st_sent;
        logic          tx_act;
        logic [CW-1:0] tx_idx;
        logic [CW-1:0] tx_len;
        logic          resp_v;
        hs_e           resp_code;
        logic [2:0]    irq;
    } st_t;

    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [CW-1:0] SU_LEN  = CW'(SETUP_LEN);

    st_t d, q;
    logic ep0_tok, status_in;

    assign ep0_tok   = tok_valid && (tok_ep == 4'd0);
    // status runs IN unless the data stage itself is IN
    assign status_in = !(q.dir_in && q.wl_nz);

    always_comb begin
        d = q;
        d.resp_v = 1'b0;
        // outgoing byte stream
        if (q.tx_act) begin
            if (q.tx_idx + CW'(1) == q.tx_len) d.tx_act = 1'b0;
            else d.tx_idx = q.tx_idx + CW'(1);
        end
        // CPU side
        if (wr_stall) d.stall = cpu_wdata[0];
        if (wr_irq) d.irq = q.irq & ~cpu_wdata[2:0];
        if (wr_in_cnt && !q.in_busy) begin
            d.in_busy = 1'b1;
            d.in_cnt  = ({1'b0, cpu_wdata} > 9'(DEPTH)) ? CNT_MAX : CW'(cpu_wdata);
        end
        if (wr_out_rel) d.out_busy = 1'b0;
        // received bytes
        if (rx_valid && q.rxk != RX_NONE) begin
            if (q.rxk == RX_SETUP) begin
                if (q.rx_cnt == '0) d.dir_in = rx_data[7];
                if ((q.rx_cnt == CW'(6) || q.rx_cnt == CW'(7)) && rx_data != 8'd0) d.wl_nz = 1'b1;
            end
            if (q.rx_cnt != CNT_MAX) d.rx_cnt = q.rx_cnt + CW'(1);
        end
        // tokens
        if (ep0_tok) begin
            d.rx_cnt = '0;
            d.rxk    = RX_NONE;
            case (pid_e'(tok_pid))
                PID_SETUP: begin
                    d.rxk      = RX_SETUP;
                    d.phase    = PH_IDLE;
                    d.dir_in   = 1'b0;
                    d.wl_nz    = 1'b0;
                    d.stall    = 1'b0;
                    d.in_busy  = 1'b0;
                    d.out_busy = 1'b0;
                    d.in_sent  = 1'b0;
                    d.st_sent  = 1'b0;
                    d.tx_act   = 1'b0;
                end
                PID_OUT: begin
                    d.rxk  = RX_OUT;
                    d.take = (q.phase == PH_DATA) && !q.dir_in && !q.out_busy && !q.stall;
                end
                PID_IN: begin
                    d.resp_v    = 1'b1;
                    d.resp_code = HS_NAK;
                    if (q.phase != PH_IDLE && q.stall) begin
                        d.resp_code = HS_STALL;
                    end else if (q.phase == PH_DATA && q.dir_in) begin
                        if (q.in_busy) begin
                            d.resp_code = HS_DATA;
                            d.tx_len    = q.in_cnt;
                            d.tx_idx    = '0;
                            d.tx_act    = (q.in_cnt != '0);
                            d.in_sent   = 1'b1;
                        end
                    end else if (q.phase != PH_IDLE && status_in) begin
                        if (!q.out_busy) begin
                            d.resp_code = HS_DATA;
                            d.tx_len    = '0;
                            d.tx_act    = 1'b0;
                            d.st_sent   = 1'b1;
                            d.phase     = PH_STATUS;
                        end
                    end
                end
                default: ;
            endcase
        end
        // end of received packet
        if (rx_end && q.rxk != RX_NONE) begin
            d.rxk = RX_NONE;
            if (q.rxk == RX_SETUP) begin
                if (q.rx_cnt == SU_LEN) begin
                    d.resp_v         = 1'b1;
                    d.resp_code      = HS_ACK;
                    d.irq[IRQ_SETUP] = 1'b1;
                    d.phase          = q.wl_nz ? PH_DATA : PH_STATUS;
                end
            end else begin
                d.resp_v    = 1'b1;
                d.resp_code = HS_NAK;
                if (q.phase != PH_IDLE && q.stall) begin
                    d.resp_code = HS_STALL;
                end else if (q.phase == PH_DATA && !q.dir_in) begin
                    if (q.take) begin
                        d.resp_code     = HS_ACK;
                        d.out_busy      = 1'b1;
                        d.out_cnt       = q.rx_cnt;
                        d.irq[IRQ_DATA] = 1'b1;
                    end
                end else if (q.phase != PH_IDLE && !status_in) begin
                    d.resp_code       = HS_ACK;
                    d.irq[IRQ_STATUS] = 1'b1;
                    d.phase           = PH_IDLE;
                end
            end
        end
        // host acknowledged our IN packet
        if (ack_in) begin
            if (q.in_sent) begin
                d.in_sent       = 1'b0;
                d.in_busy       = 1'b0;
                d.irq[IRQ_DATA] = 1'b1;
            end
            if (q.st_sent) begin
                d.st_sent         = 1'b0;
                d.irq[IRQ_STATUS] = 1'b1;
                d.phase           = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign setup_we    = (q.rxk == RX_SETUP) && rx_valid && (q.rx_cnt < SU_LEN);
    assign setup_waddr = q.rx_cnt[2:0];
    assign out_we      = (q.rxk == RX_OUT) && q.take && rx_valid && (q.rx_cnt < CNT_MAX);
    assign out_waddr   = q.rx_cnt[AW-1:0];
    assign tx_raddr    = q.tx_idx[AW-1:0];
    assign resp_valid  = q.resp_v;
    assign resp_code   = q.resp_code;
    assign tx_len      = q.tx_len;
    assign tx_valid    = q.tx_act;
    assign tx_last     = q.tx_act && (q.tx_idx + CW'(1) == q.tx_len);
    assign phase       = q.phase;
    assign irq         = q.irq;
    assign stall       = q.stall;
    assign in_busy     = q.in_busy;
    assign in_cnt      = q.in_cnt;
    assign out_busy    = q.out_busy;
    assign out_cnt     = q.out_cnt;

    // R2
    setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq[IRQ_SETUP]) |-> (q.resp_v && q.resp_code == HS_ACK));

    // R4
    data_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.resp_v && q.resp_code == HS_DATA && q.tx_len != '0) |-> q.in_busy);

    // R4
    tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.tx_act) |-> (q.resp_v && q.resp_code == HS_DATA));

    // R7
    status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq[IRQ_STATUS]) |-> q.phase == PH_IDLE);

    // R8
    stall_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.resp_v && q.resp_code == HS_STALL) |-> $past(q.stall));
endmodule

// File: rtl/ep0_engine.sv
module ep0_engine import ep0_pkg::*; #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int CPU_AW = AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_pid,
    input  logic [3:0]        tok_ep,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_end,
    input  logic              ack_in,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    output logic [CW-1:0]     tx_len,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              irq_setup,
    output logic              irq_data,
    output logic              irq_status,
    output logic [1:0]        ctl_phase
);
    localparam int REG_BASE  = 2 * DEPTH + SETUP_LEN;
    localparam logic [CPU_AW-1:0] A_INCNT  = CPU_AW'(REG_BASE);
    localparam logic [CPU_AW-1:0] A_OUTCNT = CPU_AW'(REG_BASE + 1);
    localparam logic [CPU_AW-1:0] A_CTRL   = CPU_AW'(REG_BASE + 2);
    localparam logic [CPU_AW-1:0] A_IRQ    = CPU_AW'(REG_BASE + 3);
    localparam logic [CPU_AW-1:0] A_VALID  = CPU_AW'(REG_BASE + 4);

    logic [1:0]    region;
    logic          su_sel;
    logic          setup_we, out_we, in_we;
    logic [2:0]    setup_waddr;
    logic [AW-1:0] out_waddr, tx_raddr;
    logic [7:0]    su_rdata, out_rdata;
    logic [2:0]    irq;
    logic          stall, in_busy, out_busy;
    logic [CW-1:0] in_cnt, out_cnt;

    assign region = cpu_addr[CPU_AW-1:AW];
    assign su_sel = (region == 2'd2) && (cpu_addr[AW-1:3] == '0);
    assign in_we  = cpu_we && (region == 2'd0) && !in_busy;

    ep0_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_ep(tok_ep),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end), .ack_in(ack_in),
        .wr_stall(cpu_we && cpu_addr == A_CTRL),
        .wr_irq(cpu_we && cpu_addr == A_IRQ),
        .wr_in_cnt(cpu_we && cpu_addr == A_INCNT),
        .wr_out_rel(cpu_we && cpu_addr == A_OUTCNT),
        .cpu_wdata(cpu_wdata),
        .setup_we(setup_we), .setup_waddr(setup_waddr),
        .out_we(out_we), .out_waddr(out_waddr), .tx_raddr(tx_raddr),
        .resp_valid(resp_valid), .resp_code(resp_code), .tx_len(tx_len),
        .tx_valid(tx_valid), .tx_last(tx_last), .phase(ctl_phase), .irq(irq),
        .stall(stall), .in_busy(in_busy), .in_cnt(in_cnt),
        .out_busy(out_busy), .out_cnt(out_cnt)
    );

    ep0_bytebuf #(.DEPTH(SETUP_LEN)) u_setup_buf (
        .clk(clk), .we(setup_we), .waddr(setup_waddr), .wdata(rx_data),
        .raddr(cpu_addr[2:0]), .rdata(su_rdata)
    );

    ep0_bytebuf #(.DEPTH(DEPTH)) u_in_buf (
        .clk(clk), .we(in_we), .waddr(cpu_addr[AW-1:0]), .wdata(cpu_wdata),
        .raddr(tx_raddr), .rdata(tx_data)
    );

    ep0_bytebuf #(.DEPTH(DEPTH)) u_out_buf (
        .clk(clk), .we(out_we), .waddr(out_waddr), .wdata(rx_data),
        .raddr(cpu_addr[AW-1:0]), .rdata(out_rdata)
    );

    always_comb begin
        cpu_rdata = 8'd0;
        if (region == 2'd1) cpu_rdata = out_rdata;
        else if (su_sel) cpu_rdata = su_rdata;
        else if (cpu_addr == A_INCNT) cpu_rdata = 8'(in_cnt);
        else if (cpu_addr == A_OUTCNT) cpu_rdata = 8'(out_cnt);
        else if (cpu_addr == A_CTRL) cpu_rdata = {5'd0, out_busy, in_busy, stall};
        else if (cpu_addr == A_IRQ) cpu_rdata = {5'd0, irq};
        else if (cpu_addr == A_VALID) cpu_rdata = 8'h03;
    end

    assign irq_setup  = irq[IRQ_SETUP];
    assign irq_data   = irq[IRQ_DATA];
    assign irq_status = irq[IRQ_STATUS];
endmodule

// File: tb/ep0_engine_bench.sv
module ep0_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_pid = 2'd0;
    logic [3:0] tok_ep = 4'd0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       rx_end = 1'b0;
    logic       ack_in = 1'b0;
    logic       resp_valid;
    logic [1:0] resp_code;
    logic [6:0] tx_len;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_last;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_addr = 8'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       irq_setup, irq_data, irq_status;
    logic [1:0] ctl_phase;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ep0_engine u_ep0_engine (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_ep(tok_ep),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end), .ack_in(ack_in),
        .resp_valid(resp_valid), .resp_code(resp_code), .tx_len(tx_len),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq_setup(irq_setup), .irq_data(irq_data), .irq_status(irq_status), .ctl_phase(ctl_phase)
    );

    // {request type, length low byte, expected phase}
    localparam logic [17:0] SETUP_VEC [4] = '{
        {8'h80, 8'h12, 2'd1},
        {8'h00, 8'h00, 2'd2},
        {8'h00, 8'h08, 2'd1},
        {8'h80, 8'h00, 2'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tok(input logic [1:0] pid, input logic [3:0] ep);
        @(negedge clk);
        tok_valid = 1'b1; tok_pid = pid; tok_ep = ep;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic pkt(input logic [63:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = b[8*i +: 8];
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_end = 1'b1;
        @(negedge clk);
        rx_end = 1'b0;
    endtask

    task automatic setup(input logic [3:0] ep, input logic [7:0] bm, input logic [7:0] wl);
        tok(2'd0, ep);
        pkt({8'h00, wl, 8'h00, 8'h00, 8'h00, 8'h01, 8'h06, bm}, 8);
    endtask

    task automatic cpu_wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = v;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [7:0] a, output logic [7:0] v);
        cpu_addr = a;
        #1;
        v = cpu_rdata;
    endtask

    task automatic host_ack();
        @(negedge clk);
        ack_in = 1'b1;
        @(negedge clk);
        ack_in = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        int cnt;
        int last_at;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 phase", ctl_phase, 0);
        check("R1 irq", {irq_status, irq_data, irq_setup}, 0);
        check("R1 resp", resp_valid, 0);
        cpu_rd(8'h8B, v); check("R1 irq reg", v, 0);
        // R11 valid bits
        cpu_rd(8'h8C, v); check("R11 valid", v, 8'h03);
        cpu_wr(8'h8C, 8'h00);
        cpu_rd(8'h8C, v); check("R11 valid after write", v, 8'h03);
        // R12 idle tokens
        tok(2'd2, 4'd0);
        check("R12 IN idle valid", resp_valid, 1); check("R12 IN idle NAK", resp_code, 1);
        tok(2'd1, 4'd0); pkt(64'd0, 0);
        check("R12 OUT idle NAK", {resp_valid, resp_code}, {1'b1, 2'd1});
        // R13 short setup
        tok(2'd0, 4'd0); pkt(64'h0000_0000_0001_0680, 5);
        check("R13 no resp", resp_valid, 0);
        check("R13 no irq", irq_setup, 0);
        check("R13 phase", ctl_phase, 0);

        // R2 table of setup packets
        foreach (SETUP_VEC[k]) begin
            setup(4'd0, SETUP_VEC[k][17:10], SETUP_VEC[k][9:2]);
            check("R2 ack", {resp_valid, resp_code}, {1'b1, 2'd0});
            check("R2 irq_setup", irq_setup, 1);
            check("R2 phase", ctl_phase, SETUP_VEC[k][1:0]);
            cpu_rd(8'h80, v); check("R2 byte0", v, SETUP_VEC[k][17:10]);
            cpu_rd(8'h86, v); check("R2 byte6", v, SETUP_VEC[k][9:2]);
            cpu_wr(8'h8B, 8'h01);
            check("R10 clear setup", irq_setup, 0);
        end

        // R3 foreign endpoint
        setup(4'd5, 8'h80, 8'h33);
        check("R3 no resp", resp_valid, 0);
        check("R3 no irq", irq_setup, 0);
        check("R3 phase kept", ctl_phase, 2);
        cpu_rd(8'h86, v); check("R3 setup buf kept", v, 8'h00);
        tok(2'd2, 4'd3);
        check("R3 IN foreign", resp_valid, 0);

        // control read: R4, R5, R7 OUT status
        setup(4'd0, 8'h80, 8'h03);
        tok(2'd2, 4'd0);
        check("R4 NAK unarmed", {resp_valid, resp_code}, {1'b1, 2'd1});
        cpu_wr(8'h00, 8'hA1); cpu_wr(8'h01, 8'hA2); cpu_wr(8'h02, 8'hA3);
        cpu_wr(8'h88, 8'd3);
        cpu_rd(8'h8A, v); check("R4 armed flag", v[1], 1);
        tok(2'd2, 4'd0);
        check("R4 DATA", {resp_valid, resp_code}, {1'b1, 2'd3});
        check("R4 len", tx_len, 3);
        check("R4 byte0", {tx_valid, tx_last, tx_data}, {2'b10, 8'hA1});
        @(negedge clk);
        check("R4 byte1", {tx_valid, tx_last, tx_data}, {2'b10, 8'hA2});
        @(negedge clk);
        check("R4 byte2", {tx_valid, tx_last, tx_data}, {2'b11, 8'hA3});
        @(negedge clk);
        check("R4 stream end", tx_valid, 0);
        host_ack();
        check("R5 irq_data", irq_data, 1);
        cpu_rd(8'h8A, v); check("R5 armed cleared", v[1], 0);
        tok(2'd1, 4'd0); pkt(64'd0, 0);
        check("R7 OUT status ack", {resp_valid, resp_code}, {1'b1, 2'd0});
        check("R7 irq_status", irq_status, 1);
        check("R7 phase idle", ctl_phase, 0);
        cpu_wr(8'h8B, 8'h07);

        // control write: R6, R7 IN status
        setup(4'd0, 8'h00, 8'h02);
        tok(2'd1, 4'd0); pkt(64'h6655, 2);
        check("R6 ack", {resp_valid, resp_code}, {1'b1, 2'd0});
        check("R6 irq_data", irq_data, 1);
        cpu_rd(8'h89, v); check("R6 count", v, 2);
        cpu_rd(8'h40, v); check("R6 byte0", v, 8'h55);
        cpu_rd(8'h41, v); check("R6 byte1", v, 8'h66);
        tok(2'd1, 4'd0); pkt(64'h77, 1);
        check("R6 busy NAK", {resp_valid, resp_code}, {1'b1, 2'd1});
        cpu_rd(8'h40, v); check("R6 buffer kept", v, 8'h55);
        tok(2'd2, 4'd0);
        check("R7 status NAK while busy", {resp_valid, resp_code}, {1'b1, 2'd1});
        cpu_wr(8'h89, 8'h00);
        cpu_rd(8'h8A, v); check("R6 released", v[2], 0);
        tok(2'd2, 4'd0);
        check("R7 ZLP", {resp_valid, resp_code, tx_len}, {1'b1, 2'd3, 7'd0});
        check("R7 ZLP no bytes", tx_valid, 0);
        check("R7 phase status", ctl_phase, 2);
        host_ack();
        check("R7 IN status irq", irq_status, 1);
        check("R7 IN status idle", ctl_phase, 0);
        cpu_wr(8'h8B, 8'h07);

        // R8 stall, R9 abort
        setup(4'd0, 8'h80, 8'h04);
        cpu_wr(8'h8A, 8'h01);
        tok(2'd2, 4'd0);
        check("R8 IN stall", {resp_valid, resp_code}, {1'b1, 2'd2});
        tok(2'd1, 4'd0); pkt(64'd0, 0);
        check("R8 OUT stall", {resp_valid, resp_code}, {1'b1, 2'd2});
        cpu_wr(8'h88, 8'd2);
        cpu_rd(8'h8A, v); check("R9 before abort", v, 8'h03);
        setup(4'd0, 8'h80, 8'h04);
        check("R9 abort ack", {resp_valid, resp_code}, {1'b1, 2'd0});
        cpu_rd(8'h8A, v); check("R9 flags cleared", v, 8'h00);
        check("R9 phase restart", ctl_phase, 1);

        // R10 write-one-to-clear
        cpu_wr(8'h8B, 8'h00);
        cpu_rd(8'h8B, v); check("R10 zero write keeps", v, 8'h01);
        cpu_wr(8'h8B, 8'h01);
        cpu_rd(8'h8B, v); check("R10 one write clears", v, 8'h00);

        // R4 clamp to buffer size
        cpu_wr(8'h88, 8'd100);
        tok(2'd2, 4'd0);
        check("R4 clamp len", tx_len, 64);
        cnt = 0; last_at = 0;
        while (tx_valid === 1'b1 && cnt < 80) begin
            cnt++;
            if (tx_last === 1'b1) last_at = cnt;
            @(negedge clk);
        end
        check("R4 clamp bytes", cnt, 64);
        check("R4 clamp last", last_at, 64);

        summary();
        $finish;
    end
endmodule